// File: doc/BRIEF.md
# Helper-thread fork and injection sequencer

This block sits next to the rename stage of an out-of-order core. It watches the main thread's renamed instruction stream for trigger PCs. A trigger PC that matches a loaded table entry starts a speculative helper thread in a free context. The block takes a copy of the main thread's register map as it stood in the trigger cycle. It then feeds a stored list of helper instructions, with their PCs, into the rename/issue path, one instruction per granted slot.

The helper list is replayed exactly as stored. Its PCs need not be sequential, and the block never decodes branch instructions inside the list. Every injected slot is tagged so that the pipeline gives it no reorder-buffer entry and never retires it. Injection keeps to dataflow pace: a context issues its next instruction only once the previous one has reported completion. A held exception from a helper instruction surfaces when the main thread consumes that instruction. At that point the abort input ends the rest of that helper program. Triggers that come from a helper thread are ignored, so helpers never chain.

Top module: `helper_fork_seq`

## Requirements
- R1: Out of reset, no injection and no snapshot are presented, and every context is free.
- R2: A trigger with trig_helper_i=0, whose PC equals the tag of a table entry with non-zero length, forks when a context is free. It takes the lowest-numbered free context. One cycle later snap_valid_o is 1, snap_ctx_o names that context and snap_map_o equals map_i from the trigger cycle.
- R3: A trigger with trig_helper_i=1 is ignored, and so is a trigger whose PC matches no entry of non-zero length. Neither produces a snapshot or any injection.
- R4: A forked context injects the program-memory entries start, start+1, ... in that order, wrapping from the last address to address 0. inj_pc_o and inj_insn_o carry the stored values unchanged, whatever the instruction encodes. inj_no_rob_o is 1 on every valid slot.
- R5: A context injects exactly the entry's length (1 to 64) of instructions. It becomes free in the cycle after the completion of its last instruction.
- R6: A new fork starts from the stored start pointer of its own entry, not from where an earlier program on that context stopped.
- R7: After a context's instruction is accepted (inj_valid_o=1, inj_stall_i=0), that context presents no further instruction until done_i[ctx] has been pulsed. It may present again in the cycle after the pulse.
- R8: While inj_stall_i=1 with a valid slot, the next cycle shows the same valid slot (instruction, PC, context), and the program pointer does not advance.
- R9: abort_valid_i for a context ends its program. From the next cycle on, that context injects nothing more, and it is free for a new fork.
- R10: A trigger that arrives while all contexts are busy is dropped, with no snapshot.
- R11: When several contexts are ready and no stalled slot is held, the lowest-numbered context injects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tab_we_i | input | 1 | Trigger table write enable |
| tab_slot_i | input | 2 | Trigger table slot written |
| tab_pc_i | input | 16 | Trigger PC tag for the slot |
| tab_start_i | input | 6 | Program start pointer for the slot |
| tab_len_i | input | 7 | Program length (0 marks the slot empty) |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | 6 | Program memory address |
| prog_insn_i | input | 32 | Helper instruction word |
| prog_pc_i | input | 16 | PC stored with the instruction |
| trig_valid_i | input | 1 | Renamed instruction valid for trigger match |
| trig_helper_i | input | 1 | Instruction belongs to a helper thread |
| trig_pc_i | input | 16 | PC of the renamed instruction |
| map_i | input | 24 | Current main-thread register map (4 x 6 bits) |
| snap_valid_o | output | 1 | Snapshot write strobe |
| snap_ctx_o | output | 1 | Context receiving the snapshot |
| snap_map_o | output | 24 | Map copy taken in the trigger cycle |
| inj_valid_o | output | 1 | Injection slot valid |
| inj_insn_o | output | 32 | Injected instruction |
| inj_pc_o | output | 16 | PC of the injected instruction |
| inj_ctx_o | output | 1 | Helper context of the slot |
| inj_no_rob_o | output | 1 | Slot needs no reorder-buffer entry and is never retired |
| inj_stall_i | input | 1 | Downstream cannot take the slot |
| done_i | input | 2 | Per-context completion pulse of the last injected instruction |
| abort_valid_i | input | 1 | Held helper exception raised; abort a context |
| abort_ctx_i | input | 1 | Context to abort |

## Verification
A snapshot is due one cycle after its trigger cycle, and the first instruction of a new program is visible in that same cycle. Each later instruction of a context appears no earlier than the cycle after its done pulse. A freed or aborted context can fork again one cycle after the final completion or the abort. The bench drives inputs just after each rising edge and samples outputs one time unit later in the same cycle. The consumer model issues done pulses at a set latency after each accepted slot and marks any slot that arrives while its own record shows an outstanding instruction. Stall holds are compared slot by slot against the previous cycle, and the collected streams are compared arithmetically with the contents written to program memory.

// File: rtl/helper_fork_pkg.sv
package helper_fork_pkg;
  localparam int unsigned HF_PC_W    = 16;
  localparam int unsigned HF_INSN_W  = 32;
  localparam int unsigned HF_DEPTH   = 64;
  localparam int unsigned HF_MAX_LEN = 64;
  localparam int unsigned HF_NCTX    = 2;
  localparam int unsigned HF_TRIG_N  = 4;
  localparam int unsigned HF_AREGS   = 4;
  localparam int unsigned HF_PREG_W  = 6;

  typedef enum logic {
    CTX_IDLE = 1'b0,
    CTX_RUN  = 1'b1
  } ctx_state_e;
endpackage

// File: rtl/hfs_trig_table.sv
module hfs_trig_table #(
  parameter int unsigned TRIG_N = 4,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned PTR_W  = 6,
  parameter int unsigned LEN_W  = 7,
  localparam int unsigned SLOT_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PC_W-1:0]   wpc_i,
  input  logic [PTR_W-1:0]  wstart_i,
  input  logic [LEN_W-1:0]  wlen_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              hit_o,
  output logic [PTR_W-1:0]  start_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [PC_W-1:0]  tag_q   [TRIG_N];
  logic [PTR_W-1:0] start_q [TRIG_N];
  logic [LEN_W-1:0] len_q   [TRIG_N];
  logic [TRIG_N-1:0] match;

  for (genvar i = 0; i < TRIG_N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[i]   <= '0;
        start_q[i] <= '0;
        len_q[i]   <= '0;
      end else if (we_i && slot_i == SLOT_W'(i)) begin
        tag_q[i]   <= wpc_i;
        start_q[i] <= wstart_i;
        len_q[i]   <= wlen_i;
      end
    end
    assign match[i] = (len_q[i] != '0) && (tag_q[i] == pc_i);
  end

  // lowest matching slot wins
  always_comb begin
    hit_o   = 1'b0;
    start_o = '0;
    len_o   = '0;
    for (int i = TRIG_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o   = 1'b1;
        start_o = start_q[i];
        len_o   = len_q[i];
      end
    end
  end
endmodule

// File: rtl/hfs_prog_mem.sv
module hfs_prog_mem #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned PC_W   = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [INSN_W-1:0] winsn_i,
  input  logic [PC_W-1:0]   wpc_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [INSN_W-1:0] rinsn_o,
  output logic [PC_W-1:0]   rpc_o
);
  logic [INSN_W-1:0] insn_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      insn_q[waddr_i] <= winsn_i;
      pc_q[waddr_i]   <= wpc_i;
    end
  end

  assign rinsn_o = insn_q[raddr_i];
  assign rpc_o   = pc_q[raddr_i];
endmodule

// File: rtl/hfs_ctx.sv
module hfs_ctx
  import helper_fork_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fork_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             accept_i,
  input  logic             done_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             ready_o,
  output logic [PTR_W-1:0] ptr_o
);
  ctx_state_e       state_q, state_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             infl_q, infl_n;

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    rem_n   = rem_q;
    infl_n  = infl_q;
    if (abort_i) begin
      state_n = CTX_IDLE;
      rem_n   = '0;
      infl_n  = 1'b0;
    end else if (state_q == CTX_IDLE) begin
      if (fork_i) begin
        state_n = CTX_RUN;
        ptr_n   = start_i;
        rem_n   = len_i;
        infl_n  = 1'b0;
      end
    end else begin
      if (accept_i) begin
        ptr_n  = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        rem_n  = rem_q - 1'b1;
        infl_n = 1'b1;
      end else if (done_i) begin
        infl_n = 1'b0;
      end
      // free once the last instruction has completed
      if (rem_n == '0 && !infl_n) state_n = CTX_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTX_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      infl_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      rem_q   <= rem_n;
      infl_q  <= infl_n;
    end
  end

  assign busy_o  = (state_q == CTX_RUN);
  assign ready_o = busy_o && (rem_q != '0) && !infl_q;
  assign ptr_o   = ptr_q;

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= LEN_W'(MAX_LEN)); // R5
  AST_ACCEPT_ONLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> ready_o); // R7
endmodule

// File: rtl/hfs_inj_arb.sv
module hfs_inj_arb #(
  parameter int unsigned NCTX = 2,
  localparam int unsigned CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCTX-1:0]  ready_i,
  input  logic             stall_i,
  output logic             valid_o,
  output logic [CTX_W-1:0] sel_o,
  output logic [NCTX-1:0]  accept_o
);
  logic             lock_q;
  logic [CTX_W-1:0] lock_ctx_q;

  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    if (lock_q && ready_i[lock_ctx_q]) begin
      valid_o = 1'b1;
      sel_o   = lock_ctx_q;
    end else begin
      for (int c = NCTX - 1; c >= 0; c--) begin
        if (ready_i[c]) begin
          valid_o = 1'b1;
          sel_o   = CTX_W'(c);
        end
      end
    end
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_acc
    assign accept_o[c] = valid_o && !stall_i && (sel_o == CTX_W'(c));
  end

  // a stalled slot keeps its context until taken or aborted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_ctx_q <= '0;
    end else begin
      lock_q     <= valid_o && stall_i;
      lock_ctx_q <= sel_o;
    end
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(accept_o)); // R11
endmodule

// File: rtl/helper_fork_seq.sv
module helper_fork_seq
  import helper_fork_pkg::*;
#(
  parameter int unsigned NCTX    = HF_NCTX,
  parameter int unsigned TRIG_N  = HF_TRIG_N,
  parameter int unsigned DEPTH   = HF_DEPTH,
  parameter int unsigned MAX_LEN = HF_MAX_LEN,
  parameter int unsigned PC_W    = HF_PC_W,
  parameter int unsigned INSN_W  = HF_INSN_W,
  parameter int unsigned AREGS   = HF_AREGS,
  parameter int unsigned PREG_W  = HF_PREG_W,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int unsigned SLOT_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1,
  localparam int unsigned MAP_W  = AREGS * PREG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tab_we_i,
  input  logic [SLOT_W-1:0] tab_slot_i,
  input  logic [PC_W-1:0]   tab_pc_i,
  input  logic [PTR_W-1:0]  tab_start_i,
  input  logic [LEN_W-1:0]  tab_len_i,
  input  logic              prog_we_i,
  input  logic [PTR_W-1:0]  prog_addr_i,
  input  logic [INSN_W-1:0] prog_insn_i,
  input  logic [PC_W-1:0]   prog_pc_i,
  input  logic              trig_valid_i,
  input  logic              trig_helper_i,
  input  logic [PC_W-1:0]   trig_pc_i,
  input  logic [MAP_W-1:0]  map_i,
  output logic              snap_valid_o,
  output logic [CTX_W-1:0]  snap_ctx_o,
  output logic [MAP_W-1:0]  snap_map_o,
  output logic              inj_valid_o,
  output logic [INSN_W-1:0] inj_insn_o,
  output logic [PC_W-1:0]   inj_pc_o,
  output logic [CTX_W-1:0]  inj_ctx_o,
  output logic              inj_no_rob_o,
  input  logic              inj_stall_i,
  input  logic [NCTX-1:0]   done_i,
  input  logic              abort_valid_i,
  input  logic [CTX_W-1:0]  abort_ctx_i
);
  logic             hit;
  logic [PTR_W-1:0] hit_start;
  logic [LEN_W-1:0] hit_len;
  logic [NCTX-1:0]  busy, ready, fork_vec, accept_vec, abort_vec;
  logic [PTR_W-1:0] ptr_w [NCTX];
  logic             any_free, fork_ok;
  logic [CTX_W-1:0] fork_ctx, sel;
  logic [PTR_W-1:0] rd_addr;

  hfs_trig_table #(.TRIG_N(TRIG_N), .PC_W(PC_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_tab (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(tab_we_i), .slot_i(tab_slot_i), .wpc_i(tab_pc_i),
    .wstart_i(tab_start_i), .wlen_i(tab_len_i),
    .pc_i(trig_pc_i), .hit_o(hit), .start_o(hit_start), .len_o(hit_len)
  );

  // lowest free context takes the fork
  always_comb begin
    any_free = 1'b0;
    fork_ctx = '0;
    for (int c = NCTX - 1; c >= 0; c--) begin
      if (!busy[c]) begin
        any_free = 1'b1;
        fork_ctx = CTX_W'(c);
      end
    end
  end

  // helper-thread triggers never fork (no chaining)
  assign fork_ok = trig_valid_i && !trig_helper_i && hit && any_free;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    assign fork_vec[c]  = fork_ok && (fork_ctx == CTX_W'(c));
    assign abort_vec[c] = abort_valid_i && (abort_ctx_i == CTX_W'(c));
    hfs_ctx #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_ctx (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .fork_i(fork_vec[c]), .start_i(hit_start), .len_i(hit_len),
      .accept_i(accept_vec[c]), .done_i(done_i[c]), .abort_i(abort_vec[c]),
      .busy_o(busy[c]), .ready_o(ready[c]), .ptr_o(ptr_w[c])
    );
  end

  hfs_inj_arb #(.NCTX(NCTX)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ready_i(ready), .stall_i(inj_stall_i),
    .valid_o(inj_valid_o), .sel_o(sel), .accept_o(accept_vec)
  );

  assign rd_addr = ptr_w[sel];

  hfs_prog_mem #(.DEPTH(DEPTH), .INSN_W(INSN_W), .PC_W(PC_W)) u_mem (
    .clk_i(clk_i), .we_i(prog_we_i), .waddr_i(prog_addr_i),
    .winsn_i(prog_insn_i), .wpc_i(prog_pc_i),
    .raddr_i(rd_addr), .rinsn_o(inj_insn_o), .rpc_o(inj_pc_o)
  );

  assign inj_ctx_o    = sel;
  assign inj_no_rob_o = inj_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_valid_o <= 1'b0;
      snap_ctx_o   <= '0;
      snap_map_o   <= '0;
    end else begin
      snap_valid_o <= fork_ok;
      if (fork_ok) begin
        snap_ctx_o <= fork_ctx;
        snap_map_o <= map_i;
      end
    end
  end

  AST_HELPER_NO_FORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_i && trig_helper_i) |=> !snap_valid_o); // R3
  AST_PACE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_o && !inj_stall_i) |=> !(inj_valid_o && inj_ctx_o == $past(inj_ctx_o))); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_o && inj_stall_i && !prog_we_i && !(abort_valid_i && abort_ctx_i == inj_ctx_o))
      |=> (inj_valid_o && $stable(inj_pc_o) && $stable(inj_insn_o) && $stable(inj_ctx_o))); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_valid_i |=> !(inj_valid_o && inj_ctx_o == $past(abort_ctx_i))); // R9
endmodule

// File: tb/helper_fork_seq_tb.sv
`timescale 1ns/1ps
module helper_fork_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tab_we_i = 0;
  logic [1:0]  tab_slot_i = 0;
  logic [15:0] tab_pc_i = 0;
  logic [5:0]  tab_start_i = 0;
  logic [6:0]  tab_len_i = 0;
  logic        prog_we_i = 0;
  logic [5:0]  prog_addr_i = 0;
  logic [31:0] prog_insn_i = 0;
  logic [15:0] prog_pc_i = 0;
  logic        trig_valid_i = 0, trig_helper_i = 0;
  logic [15:0] trig_pc_i = 0;
  logic [23:0] map_i = 0;
  logic        snap_valid_o;
  logic [0:0]  snap_ctx_o;
  logic [23:0] snap_map_o;
  logic        inj_valid_o, inj_no_rob_o;
  logic [31:0] inj_insn_o;
  logic [15:0] inj_pc_o;
  logic [0:0]  inj_ctx_o;
  logic        inj_stall_i = 0;
  logic [1:0]  done_i = 0;
  logic        abort_valid_i = 0;
  logic [0:0]  abort_ctx_i = 0;

  always #4 clk = ~clk;

  helper_fork_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tab_we_i(tab_we_i), .tab_slot_i(tab_slot_i), .tab_pc_i(tab_pc_i),
    .tab_start_i(tab_start_i), .tab_len_i(tab_len_i),
    .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i),
    .prog_insn_i(prog_insn_i), .prog_pc_i(prog_pc_i),
    .trig_valid_i(trig_valid_i), .trig_helper_i(trig_helper_i),
    .trig_pc_i(trig_pc_i), .map_i(map_i),
    .snap_valid_o(snap_valid_o), .snap_ctx_o(snap_ctx_o), .snap_map_o(snap_map_o),
    .inj_valid_o(inj_valid_o), .inj_insn_o(inj_insn_o), .inj_pc_o(inj_pc_o),
    .inj_ctx_o(inj_ctx_o), .inj_no_rob_o(inj_no_rob_o), .inj_stall_i(inj_stall_i),
    .done_i(done_i), .abort_valid_i(abort_valid_i), .abort_ctx_i(abort_ctx_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  int  cd [2];
  bit  own_out [2];
  int  lat = 1;
  bit  stall_mode = 0;
  int  cyc_n = 0;
  bit  prev_hold = 0;
  logic [15:0] prev_pc;
  logic [31:0] prev_insn;
  logic [0:0]  prev_ctx;
  bit  last_snap_v, snap_any;
  int  last_snap_c;
  logic [23:0] last_snap_map;
  bit  last_inj_v;
  int  last_inj_c;
  int  got_cnt [2];
  logic [15:0] got_pc   [2][64];
  logic [31:0] got_insn [2][64];

  function automatic logic [15:0] exp_pc(int i);
    return 16'(32'h0100 + i * i * 3);
  endfunction
  function automatic logic [31:0] exp_insn(int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic cyc();
    logic [1:0] dn;
    int c;
    bit acc, ab_hit;
    dn = '0;
    c = 0;
    for (int k = 0; k < 2; k++) begin
      if (cd[k] != 0) begin
        cd[k]--;
        if (cd[k] == 0) dn[k] = 1'b1;
      end
    end
    done_i = dn;
    inj_stall_i = stall_mode && (cyc_n % 2 == 1);
    #1;
    last_snap_v = snap_valid_o;
    last_snap_c = int'(snap_ctx_o);
    last_snap_map = snap_map_o;
    if (snap_valid_o) snap_any = 1;
    if (prev_hold)
      chk(inj_valid_o && inj_pc_o == prev_pc && inj_insn_o == prev_insn && inj_ctx_o == prev_ctx,
          "R8", "stalled slot pc", inj_pc_o, prev_pc);
    ab_hit = abort_valid_i && (abort_ctx_i == inj_ctx_o);
    prev_hold = inj_valid_o && inj_stall_i && !ab_hit;
    prev_pc = inj_pc_o; prev_insn = inj_insn_o; prev_ctx = inj_ctx_o;
    last_inj_v = inj_valid_o;
    last_inj_c = int'(inj_ctx_o);
    acc = inj_valid_o && !inj_stall_i;
    if (acc) begin
      c = int'(inj_ctx_o);
      chk(!own_out[c], "R7", "slot while outstanding ctx", c, -1);
      chk(inj_no_rob_o, "R4", "no_rob mark", inj_no_rob_o, 1);
      if (got_cnt[c] < 64) begin
        got_pc[c][got_cnt[c]]   = inj_pc_o;
        got_insn[c][got_cnt[c]] = inj_insn_o;
      end
      got_cnt[c]++;
    end
    for (int k = 0; k < 2; k++) if (dn[k]) own_out[k] = 0;
    if (abort_valid_i) begin
      own_out[abort_ctx_i] = 0;
      cd[abort_ctx_i] = 0;
    end
    if (acc && !ab_hit) begin
      own_out[c] = 1;
      cd[c] = lat;
    end
    @(posedge clk); #1;
    trig_valid_i = 0; trig_helper_i = 0; abort_valid_i = 0;
    prog_we_i = 0; tab_we_i = 0;
    cyc_n++;
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic trig(logic [15:0] pc, bit helper, logic [23:0] m);
    trig_valid_i = 1; trig_pc_i = pc; trig_helper_i = helper; map_i = m;
    cyc();
  endtask

  task automatic clear_got();
    got_cnt[0] = 0; got_cnt[1] = 0;
  endtask

  task automatic check_seq(int c, int start, int len, string req);
    chk(got_cnt[c] == len, "R5", "injected count", got_cnt[c], len);
    for (int k = 0; k < len && k < got_cnt[c]; k++) begin
      int idx;
      idx = (start + k) % 64;
      chk(got_pc[c][k] == exp_pc(idx), req, "pc order", got_pc[c][k], exp_pc(idx));
      chk(got_insn[c][k] == exp_insn(idx), req, "insn", got_insn[c][k], exp_insn(idx));
    end
  endtask

  task automatic tab_wr(int slot, logic [15:0] pc, int start, int len);
    tab_we_i = 1; tab_slot_i = 2'(slot); tab_pc_i = pc;
    tab_start_i = 6'(start); tab_len_i = 7'(len);
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    cd[0] = 0; cd[1] = 0; own_out[0] = 0; own_out[1] = 0;
    got_cnt[0] = 0; got_cnt[1] = 0;
    @(posedge clk); #1;
    chk(!inj_valid_o && !snap_valid_o, "R1", "outputs in reset", {inj_valid_o, snap_valid_o}, 0);
    @(posedge clk); #1;
    rst_ni = 1;
    #1;
    chk(!inj_valid_o, "R1", "inj_valid after reset", inj_valid_o, 0);
    chk(!snap_valid_o, "R1", "snap_valid after reset", snap_valid_o, 0);

    for (int i = 0; i < 64; i++) begin
      prog_we_i = 1; prog_addr_i = 6'(i); prog_pc_i = exp_pc(i); prog_insn_i = exp_insn(i);
      cyc();
    end
    tab_wr(0, 16'h0400, 5, 3);
    tab_wr(1, 16'h0800, 60, 6);
    tab_wr(2, 16'h0C00, 20, 64);
    tab_wr(3, 16'h1400, 10, 1);
    chk(got_cnt[0] + got_cnt[1] == 0, "R1", "no injection while idle", got_cnt[0] + got_cnt[1], 0);

    // R3: helper-originated trigger and table miss
    snap_any = 0; clear_got();
    trig(16'h0400, 1, 24'h111111);
    run(4);
    chk(!snap_any, "R3", "snapshot from helper trigger", snap_any, 0);
    chk(got_cnt[0] + got_cnt[1] == 0, "R3", "injection from helper trigger", got_cnt[0] + got_cnt[1], 0);
    trig(16'h0404, 0, 24'h222222);
    run(4);
    chk(!snap_any, "R3", "snapshot from miss", snap_any, 0);
    chk(got_cnt[0] + got_cnt[1] == 0, "R3", "injection from miss", got_cnt[0] + got_cnt[1], 0);

    // R2 R4 R5 R7: single program, done latency 3
    lat = 3; clear_got();
    trig(16'h0400, 0, 24'hABCDEF);
    cyc();
    chk(last_snap_v, "R2", "snap_valid", last_snap_v, 1);
    chk(last_snap_c == 0, "R2", "snap_ctx", last_snap_c, 0);
    chk(last_snap_map == 24'hABCDEF, "R2", "snap_map", last_snap_map, 24'hABCDEF);
    run(20);
    check_seq(0, 5, 3, "R4");

    // R5 R6: context freed and restarted from its new entry
    clear_got();
    trig(16'h1400, 0, 24'h123456);
    cyc();
    chk(last_snap_v && last_snap_c == 0, "R5", "refork ctx", last_snap_c, 0);
    run(10);
    check_seq(0, 10, 1, "R6");

    // R8 + wrap: alternate stall cycles
    stall_mode = 1; lat = 1; clear_got();
    trig(16'h0800, 0, 24'h0F0F0F);
    run(40);
    stall_mode = 0;
    check_seq(0, 60, 6, "R4");

    // R10 R11 R9: two contexts
    lat = 8; clear_got();
    trig(16'h0C00, 0, 24'hAAAAAA);
    cyc();
    chk(last_snap_v && last_snap_c == 0, "R2", "first fork ctx", last_snap_c, 0);
    trig(16'h0400, 0, 24'h555555);
    cyc();
    chk(last_snap_v && last_snap_c == 1, "R2", "second fork ctx", last_snap_c, 1);
    chk(last_snap_map == 24'h555555, "R2", "second fork map", last_snap_map, 24'h555555);
    snap_any = 0;
    trig(16'h0800, 0, 24'h999999);
    run(2);
    chk(!snap_any, "R10", "fork while all busy", snap_any, 0);
    cd[0] = 2; cd[1] = 2;
    run(3);
    chk(last_inj_v && last_inj_c == 0, "R11", "priority ctx", last_inj_c, 0);
    cyc();
    chk(last_inj_v && last_inj_c == 1, "R11", "second ready ctx", last_inj_c, 1);

    abort_valid_i = 1; abort_ctx_i = 0;
    cyc();
    n0 = got_cnt[0];
    run(40);
    chk(got_cnt[0] == n0, "R9", "ctx0 injections after abort", got_cnt[0], n0);
    for (int k = 0; k < 2; k++)
      chk(got_pc[0][k] == exp_pc(20 + k), "R4", "ctx0 prefix pc", got_pc[0][k], exp_pc(20 + k));
    check_seq(1, 5, 3, "R4");
    trig(16'h0400, 0, 24'h777777);
    cyc();
    chk(last_snap_v && last_snap_c == 0, "R9", "aborted ctx reusable", last_snap_c, 0);
    run(20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule